// File: doc/BRIEF.md
# Key-Combination Reset Detector

The block watches a small group of general-purpose input pins and raises a reset request while every pin of a chosen combination is held low at once. A 2-bit selector picks the combination, and one selector value turns detection off. The intended use is a "hold these keys together to reset" gesture. The request goes to a reset generator outside this block.

Each pin first passes through a two-flop synchronizer on the port clock. It then has an optional debounce filter that can be enabled per pin. The filter uses a per-pin counter with a programmable threshold. When the filter is off, the synchronized level is used directly, so a short simultaneous low is enough to raise the request. When it is on, the low level must last for a minimum time before it counts.

When the port clock is stopped during sleep, the filter cannot run. The `sleep_gated` input tells the block this, and the block then routes the raw pin levels straight to the combination match. The synchronized pin levels stay readable as ordinary inputs whatever the configuration is. All pins are plain control and status signals, so there is no valid/ready stream and no back-pressure.

Top module: `key_combo_reset`

## Requirements
- R1: While reset is held and after its release, `pins_o` reads all ones, the filter state reads all ones and `key_rst_req` is low until the inputs cause otherwise.
- R2: `combo_sel` encodes the watched set: 0 watches nothing and never requests, 1 watches pins 0 and 1, 2 watches pins 0 to 2, and 3 watches every pin.
- R3: With filtering off on all pins and `sleep_gated` low, `key_rst_req` follows the synchronized levels. A change at the pins is seen after exactly two rising clock edges.
- R4: On a pin with its filter enabled, the filtered level takes the synchronized level only after the two have differed on `flt_thresh`+1 consecutive clock edges. If they agree on any edge, the count starts over.
- R5: A pin whose filter is disabled keeps its filter state equal to its synchronized level, so enabling the filter starts from the current level.
- R6: While `sleep_gated` is high, `key_rst_req` is computed from the raw `pins_i` levels without any clock edge.
- R7: `pins_o` always equals the synchronized pin levels (`pins_i` delayed by two edges), independent of `combo_sel`, `flt_en` and `sleep_gated`.
- R8: `key_rst_req` is a level. It stays high on every cycle in which all watched pins read low, and drops when any of them reads high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, which also runs the filter |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NPINS | Raw input pin levels |
| combo_sel | input | 2 | Watched-combination selector (0 = off) |
| flt_en | input | NPINS | Per-pin debounce enable |
| flt_thresh | input | CNT_W | Debounce threshold; a level must persist thresh+1 edges |
| sleep_gated | input | 1 | High while the port clock is stopped in sleep; bypasses filtering |
| pins_o | output | NPINS | Synchronized pin levels for ordinary input reads |
| key_rst_req | output | 1 | Reset request level |

## Verification
The bench aims at the debounce boundary. A low held for one edge less than the threshold must not raise the request, and a single high bounce in the middle must restart the count. A design that counted from the raw pin, or that did not clear the count, would fire early. The bench also drives selector value 0 with every pin low, where a wrong decode would request a reset. It covers the sleep bypass, where a design that still used the registered path would lag the pins by cycles. Long random runs with filters switched on and off check that enabling a filter never produces a stale level that releases or fires the request.

// File: rtl/kcr_pkg.sv
package kcr_pkg;

  typedef enum logic [1:0] {
    COMBO_OFF    = 2'd0,
    COMBO_PAIR   = 2'd1,
    COMBO_TRIPLE = 2'd2,
    COMBO_ALL    = 2'd3
  } combo_e;

  // Watched-pin mask for a selector value, returned 32 bits wide.
  function automatic logic [31:0] combo_mask(input logic [1:0] sel, input int unsigned npins);
    logic [31:0] m;
    case (combo_e'(sel))
      COMBO_OFF:    m = 32'h0;
      COMBO_PAIR:   m = 32'h3;
      COMBO_TRIPLE: m = 32'h7;
      default:      m = (npins >= 32) ? 32'hFFFF_FFFF : ((32'h1 << npins) - 32'h1);
    endcase
    return m;
  endfunction

endpackage

// File: rtl/kcr_sync.sv
module kcr_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '1;
      stage2_q <= '1;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/kcr_filter.sv
module kcr_filter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic             lvl_i,
  output logic             lvl_o
);
  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else if (!en_i) begin
      lvl_q <= lvl_i;
      cnt_q <= '0;
    end else if (lvl_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q >= thresh_i) begin
      lvl_q <= lvl_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/kcr_match.sv
module kcr_match
  import kcr_pkg::*;
#(
  parameter int unsigned NPINS = 4
) (
  input  logic [NPINS-1:0] raw_i,
  input  logic [NPINS-1:0] sync_i,
  input  logic [NPINS-1:0] filt_i,
  input  logic [NPINS-1:0] flt_en_i,
  input  logic [1:0]       sel_i,
  input  logic             bypass_i,
  output logic             req_o
);
  logic [31:0]      mask_full;
  logic [NPINS-1:0] mask;
  logic [NPINS-1:0] eff;

  always_comb begin
    mask_full = combo_mask(sel_i, NPINS);
    mask      = mask_full[NPINS-1:0];
    eff       = bypass_i ? raw_i : ((filt_i & flt_en_i) | (sync_i & ~flt_en_i));
    req_o     = (mask != '0) && ((eff & mask) == '0);
  end
endmodule

// File: rtl/key_combo_reset.sv
module key_combo_reset #(
  parameter int unsigned NPINS = 4,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic [1:0]       combo_sel,
  input  logic [NPINS-1:0] flt_en,
  input  logic [CNT_W-1:0] flt_thresh,
  input  logic             sleep_gated,
  output logic [NPINS-1:0] pins_o,
  output logic             key_rst_req
);
  logic [NPINS-1:0] sync_q;
  logic [NPINS-1:0] filt_q;

  kcr_sync #(.W(NPINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pins_i),
    .q_o  (sync_q)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    kcr_filter #(.CNT_W(CNT_W)) u_flt (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (flt_en[i]),
      .thresh_i(flt_thresh),
      .lvl_i   (sync_q[i]),
      .lvl_o   (filt_q[i])
    );
  end

  kcr_match #(.NPINS(NPINS)) u_match (
    .raw_i   (pins_i),
    .sync_i  (sync_q),
    .filt_i  (filt_q),
    .flt_en_i(flt_en),
    .sel_i   (combo_sel),
    .bypass_i(sleep_gated),
    .req_o   (key_rst_req)
  );

  assign pins_o = sync_q;
endmodule

// File: rtl/kcr_checker.sv
module kcr_checker
  import kcr_pkg::*;
#(
  parameter int unsigned NPINS = 4,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pins_i,
  input logic [1:0]       combo_sel,
  input logic [NPINS-1:0] flt_en,
  input logic             sleep_gated,
  input logic [NPINS-1:0] pins_o,
  input logic             key_rst_req,
  input logic [NPINS-1:0] sync_q,
  input logic [NPINS-1:0] filt_q
);
  logic [1:0]       age_q;
  logic [31:0]      mfull;
  logic [NPINS-1:0] msk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  always_comb begin
    mfull = combo_mask(combo_sel, NPINS);
    msk   = mfull[NPINS-1:0];
  end

  // R2: the off selector never requests
  a_r2_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (combo_sel == 2'd0) |-> !key_rst_req);

  // R6: sleep bypass works from the raw pins
  a_r6_bypass_raw: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_gated |-> (key_rst_req == ((msk != '0) && ((pins_i & msk) == '0))));

  // R3: unfiltered path follows the synchronizer output
  a_r3_direct_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_gated && flt_en == '0) |-> (key_rst_req == ((msk != '0) && ((sync_q & msk) == '0))));

  // R7: readable levels are the pins two edges back
  a_r7_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (pins_o == $past(pins_i, 2)));

  // R4: a filtered level only ever moves to the synchronized level
  a_r4_filt_moves_to_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0) |-> (((filt_q ^ $past(filt_q)) & (filt_q ^ $past(sync_q))) == '0));
endmodule

bind key_combo_reset kcr_checker #(.NPINS(NPINS), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pins_i     (pins_i),
  .combo_sel  (combo_sel),
  .flt_en     (flt_en),
  .sleep_gated(sleep_gated),
  .pins_o     (pins_o),
  .key_rst_req(key_rst_req),
  .sync_q     (sync_q),
  .filt_q     (filt_q)
);

// File: tb/tb_key_combo_reset.sv
`timescale 1ns/1ps
module tb_key_combo_reset;
  localparam int unsigned NPINS = 4;
  localparam int unsigned CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NPINS-1:0] pins_i = '1;
  logic [1:0]       combo_sel = 2'd0;
  logic [NPINS-1:0] flt_en = '0;
  logic [CNT_W-1:0] flt_thresh = '0;
  logic             sleep_gated = 1'b0;
  logic [NPINS-1:0] pins_o;
  logic             key_rst_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  key_combo_reset #(.NPINS(NPINS), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .combo_sel(combo_sel),
    .flt_en(flt_en), .flt_thresh(flt_thresh), .sleep_gated(sleep_gated),
    .pins_o(pins_o), .key_rst_req(key_rst_req)
  );

  // Reference model built from the requirement text
  logic [NPINS-1:0] m_s1, m_s2, m_f;
  int unsigned      m_cnt [NPINS];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '1; m_s2 = '1; m_f = '1;
      for (int i = 0; i < NPINS; i++) m_cnt[i] = 0;
    end else begin
      for (int i = 0; i < NPINS; i++) begin
        if (!flt_en[i]) begin m_f[i] = m_s2[i]; m_cnt[i] = 0; end        // R5
        else if (m_s2[i] == m_f[i]) m_cnt[i] = 0;                         // R4 restart
        else if (m_cnt[i] >= flt_thresh) begin m_f[i] = m_s2[i]; m_cnt[i] = 0; end
        else m_cnt[i] = m_cnt[i] + 1;
      end
      m_s2 = m_s1;
      m_s1 = pins_i;
    end
  end

  function automatic logic [NPINS-1:0] exp_mask(input logic [1:0] sel);
    case (sel)
      2'd0: return '0;
      2'd1: return 4'b0011;
      2'd2: return 4'b0111;
      default: return '1;
    endcase
  endfunction

  function automatic logic exp_req();
    logic [NPINS-1:0] e, m;
    m = exp_mask(combo_sel);
    e = sleep_gated ? pins_i : ((m_f & flt_en) | (m_s2 & ~flt_en));
    return (m != '0) && ((e & m) == '0);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic model_cmp();
    chk("R8 request level", {31'd0, key_rst_req}, {31'd0, exp_req()});
    chk("R7 synced pins", {28'd0, pins_o}, {28'd0, m_s2});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    bit seen;
    void'($urandom(32'h5EED_1234));
    cyc(3);
    chk("R1 req in reset", {31'd0, key_rst_req}, 32'd0);
    chk("R1 pins_o in reset", {28'd0, pins_o}, 32'hF);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 req after reset", {31'd0, key_rst_req}, 32'd0);

    // R2: selector 0 with everything low
    pins_i = '0; cyc(4);
    chk("R2 off selector", {31'd0, key_rst_req}, 32'd0);
    // R2/R3: pair on pins 0,1
    pins_i = 4'b1111; combo_sel = 2'd1; cyc(3);
    pins_i = 4'b1100; cyc(1);
    chk("R3 one edge not yet", {31'd0, key_rst_req}, 32'd0);
    cyc(1);
    chk("R3 two edges seen", {31'd0, key_rst_req}, 32'd1);
    combo_sel = 2'd2; #1;
    chk("R2 triple needs pin2", {31'd0, key_rst_req}, 32'd0);
    @(negedge clk);
    pins_i = 4'b1000; cyc(2);
    chk("R2 triple met", {31'd0, key_rst_req}, 32'd1);
    combo_sel = 2'd3; #1;
    chk("R2 all needs pin3", {31'd0, key_rst_req}, 32'd0);
    @(negedge clk);
    pins_i = 4'b0000; cyc(2);
    chk("R2 all met", {31'd0, key_rst_req}, 32'd1);
    cyc(5);
    chk("R8 held level", {31'd0, key_rst_req}, 32'd1);
    pins_i = 4'b0100; cyc(2);
    chk("R8 drops on release", {31'd0, key_rst_req}, 32'd0);

    // R4: debounce threshold 4 -> thresh+1 = 5 edges after sync low
    pins_i = '1; cyc(3);
    flt_thresh = 8'd4; flt_en = '1; cyc(4);
    pins_i = '0; cyc(6);
    chk("R4 before threshold", {31'd0, key_rst_req}, 32'd0);
    cyc(1);
    chk("R4 at threshold", {31'd0, key_rst_req}, 32'd1);
    pins_i = '1; cyc(8);
    chk("R4 released", {31'd0, key_rst_req}, 32'd0);
    // R4: bounce restarts the count
    pins_i = '0; cyc(4);
    pins_i = 4'b0001; cyc(1);
    pins_i = '0;
    seen = 0;
    for (int k = 0; k < 6; k++) begin @(negedge clk); if (key_rst_req) seen = 1; end
    chk("R4 bounce restarts", {31'd0, seen}, 32'd0);
    cyc(2);
    chk("R4 after restart", {31'd0, key_rst_req}, 32'd1);

    // R6: sleep bypass follows raw pins at once
    pins_i = '1; cyc(8);
    sleep_gated = 1'b1; pins_i = '0; #1;
    chk("R6 bypass low", {31'd0, key_rst_req}, 32'd1);
    pins_i = 4'b0010; #1;
    chk("R6 bypass release", {31'd0, key_rst_req}, 32'd0);
    @(negedge clk);
    sleep_gated = 1'b0; pins_i = '1; cyc(10);

    // R5: disabled pin tracks sync, enabling starts from current level
    flt_en = '0; pins_i = '0; cyc(3);
    flt_en = '1; flt_thresh = 8'd9; #1;
    chk("R5 enable keeps level", {31'd0, key_rst_req}, 32'd1);
    @(negedge clk);

    // Random phase against the model
    for (int it = 0; it < 6000; it++) begin
      @(negedge clk);
      model_cmp();
      if ($urandom_range(0, 99) < 8) pins_i = pins_i ^ NPINS'(1 << $urandom_range(0, NPINS-1));
      if ($urandom_range(0, 99) < 3) pins_i = ($urandom_range(0, 1) != 0) ? '0 : '1;
      if ($urandom_range(0, 299) == 0) combo_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 199) == 0) flt_en = NPINS'($urandom_range(0, 15));
      if (flt_en == '0 && $urandom_range(0, 49) == 0) flt_thresh = CNT_W'($urandom_range(0, 12));
      if ($urandom_range(0, 399) == 0) sleep_gated = ~sleep_gated;
      #1;
      if (sleep_gated) chk("R6 bypass random", {31'd0, key_rst_req}, {31'd0, exp_req()});
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule